// File: doc/BRIEF.md
# Transmit Byte-Ring Packet Fetcher

This block is the device half of a transmit path in which the host places outgoing packets, one after another, in a single circular byte buffer in shared memory rather than handing over a list of scattered fragments. Each packet is a 32-bit length word followed by its payload bytes. After the payload, the next length word starts at the following 4-byte boundary. The host publishes work by moving a producer index, counted in 32-bit words. The fetcher keeps its own consumer byte offset and chases the producer until the two meet.

For every packet the fetcher reads the length word, then reads the payload one 32-bit word at a time from a synchronous memory with one cycle of read latency. It hands the bytes out on a valid/ready byte stream and marks the final byte. A payload may run off the end of the buffer and continue at offset 0. When the last byte has been accepted, the fetcher writes one completion word into a status ring of 64 slots, taking the slots in order. The buffer size is programmed in 32-bit words, and its default capacity is 8192 bytes.

Top module: `tx_ring_fetch`

## Requirements
- R1: While reset is held and after it is released, `tx_valid`, `mem_rd_en` and `stat_wr_en` are low, and the consumer offset and the status slot both start at 0.
- R2: A packet begins with a read of word address `cfg_buf_base + offset/4`. The payload length is bits [15:0] of that word, and bits [31:16] have no effect on the number of bytes sent.
- R3: Payload bytes leave in buffer order. The byte at buffer offset 4k+j is bits [8j+7:8j] of buffer word k.
- R4: `tx_last` is high exactly on the final payload byte and only while `tx_valid` is high. A zero-length packet produces no byte on the stream but still produces a status entry.
- R5: The payload byte that follows buffer offset size-1 is taken from offset 0.
- R6: The next length word is at (offset + 4 + length), rounded up to a multiple of 4, modulo the buffer size.
- R7: Each finished packet writes one word to `cfg_stat_base + slot`. Bits [15:0] hold the length, bit 16 is the success flag (1), bit 31 is the update flag (1), and all other bits are 0. The slot advances by one per packet, modulo 64.
- R8: No memory read and no stream output happen while the consumer byte offset equals 4 × `host_prod_idx`. Fetching resumes when the index moves.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` stay unchanged.
- R10: The buffer size in bytes is 4 × `cfg_buf_words`, and all wrapping uses that size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_buf_base | input | 16 | Word address of the byte buffer |
| cfg_buf_words | input | 12 | Buffer size in 32-bit words |
| cfg_stat_base | input | 16 | Word address of status slot 0 |
| host_prod_idx | input | 11 | Host producer position in 32-bit words |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 16 | Memory read word address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the request |
| stat_wr_en | output | 1 | Status word write strobe |
| stat_wr_addr | output | 16 | Status word address |
| stat_wr_data | output | 32 | Status word |
| tx_data | output | 8 | Payload byte |
| tx_valid | output | 1 | Byte valid |
| tx_last | output | 1 | Final byte of the packet |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
Every length from 0 to 40 is sent through a 64-byte buffer, one packet at a time. Headers and payloads therefore land at every alignment relative to the buffer end, which separates wrap and round-up errors from plain ordering errors. Four acceptance patterns on `tx_ready` (always ready, and three differently spaced stall rhythms) show whether backpressure loses, repeats or reorders bytes. A batch of several packets published with a single index move checks back-to-back header chaining. Runs of short packets push the status slot past 64. Long packets in the full 8192-byte buffer check that wrapping follows the programmed size rather than a fixed small one.

// File: rtl/tx_fetch_pkg.sv
package tx_fetch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_WREQ,
        ST_WAIT,
        ST_SEND,
        ST_STAT
    } fetch_state_e;

    localparam int LEN_W = 16;

    // Completion word: update flag at 31, success at 16, length in the low half.
    function automatic logic [31:0] pack_status(input logic [LEN_W-1:0] len);
        return {1'b1, 14'b0, 1'b1, len};
    endfunction

endpackage

// File: rtl/tx_fetch_step.sv
// Advances a byte offset by a small step, optionally rounds it up to a word
// boundary, then folds it back into [0, size).
module tx_fetch_step #(
    parameter int OFF_W = 14
) (
    input  logic [OFF_W-1:0] off,
    input  logic [2:0]       step,
    input  logic             round_up,
    input  logic [OFF_W-1:0] size_b,
    output logic [OFF_W-1:0] nxt
);
    logic [OFF_W:0] sum;
    logic [OFF_W:0] rnd;

    always_comb begin
        sum = {1'b0, off} + {{(OFF_W-2){1'b0}}, step};
        rnd = round_up ? ((sum + 3) & ~((OFF_W+1)'(3))) : sum;
        if (rnd >= {1'b0, size_b}) begin
            rnd = rnd - {1'b0, size_b};
        end
        nxt = rnd[OFF_W-1:0];
    end
endmodule

// File: rtl/tx_fetch_status.sv
// Status slot counter and completion-word formatter.
module tx_fetch_status #(
    parameter int STAT_ENTRIES = 64,
    parameter int ADDR_W       = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           fire,
    input  logic [tx_fetch_pkg::LEN_W-1:0] len,
    input  logic [ADDR_W-1:0]              stat_base,
    output logic                           wr_en,
    output logic [ADDR_W-1:0]              wr_addr,
    output logic [31:0]                    wr_data
);
    localparam int SLOT_W = (STAT_ENTRIES > 1) ? $clog2(STAT_ENTRIES) : 1;

    logic [SLOT_W-1:0] slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (fire) begin
            slot_d = (slot_q == SLOT_W'(STAT_ENTRIES-1)) ? '0 : slot_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign wr_en   = fire;
    assign wr_addr = stat_base + ADDR_W'(slot_q);
    assign wr_data = tx_fetch_pkg::pack_status(len);

    // R7: slots are taken in ring order.
    p_slot_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (($past(slot_q) == SLOT_W'(STAT_ENTRIES-1)) ? (slot_q == '0)
                                                               : (slot_q == $past(slot_q) + 1'b1)));
    p_slot_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(slot_q));
endmodule

// File: rtl/tx_ring_fetch.sv
module tx_ring_fetch #(
    parameter int BUF_BYTES    = 8192,
    parameter int STAT_ENTRIES = 64,
    parameter int ADDR_W       = 16,
    parameter int IDX_W        = $clog2(BUF_BYTES/4)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cfg_buf_base,
    input  logic [IDX_W:0]     cfg_buf_words,
    input  logic [ADDR_W-1:0]  cfg_stat_base,
    input  logic [IDX_W-1:0]   host_prod_idx,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic [31:0]        mem_rd_data,
    output logic               stat_wr_en,
    output logic [ADDR_W-1:0]  stat_wr_addr,
    output logic [31:0]        stat_wr_data,
    output logic [7:0]         tx_data,
    output logic               tx_valid,
    output logic               tx_last,
    input  logic               tx_ready
);
    import tx_fetch_pkg::*;

    localparam int OFF_W = IDX_W + 3;

    typedef struct packed {
        fetch_state_e     st;
        logic [OFF_W-1:0] cons;
        logic [OFF_W-1:0] ptr;
        logic [LEN_W-1:0] rem;
        logic [LEN_W-1:0] len;
        logic [31:0]      word;
    } regs_t;

    regs_t r_d, r_q;

    logic [OFF_W-1:0] size_b;
    logic [OFF_W-1:0] prod_b;
    logic [OFF_W-1:0] hdr_next;
    logic [OFF_W-1:0] byte_next;
    logic [OFF_W-1:0] end_next;
    logic             stat_fire;

    assign size_b = {cfg_buf_words, 2'b00};
    assign prod_b = {1'b0, host_prod_idx, 2'b00};

    tx_fetch_step #(.OFF_W(OFF_W)) u_hdr_step (
        .off(r_q.cons), .step(3'd4), .round_up(1'b0), .size_b(size_b), .nxt(hdr_next)
    );
    tx_fetch_step #(.OFF_W(OFF_W)) u_byte_step (
        .off(r_q.ptr), .step(3'd1), .round_up(1'b0), .size_b(size_b), .nxt(byte_next)
    );
    tx_fetch_step #(.OFF_W(OFF_W)) u_end_step (
        .off(r_q.ptr), .step(3'd1), .round_up(1'b1), .size_b(size_b), .nxt(end_next)
    );

    always_comb begin
        r_d         = r_q;
        mem_rd_en   = 1'b0;
        mem_rd_addr = cfg_buf_base + ADDR_W'(r_q.cons[OFF_W-1:2]);
        stat_fire   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (r_q.cons != prod_b) begin
                    mem_rd_en = 1'b1;
                    r_d.st    = ST_HDR;
                end
            end
            ST_HDR: begin
                r_d.len = mem_rd_data[LEN_W-1:0];
                r_d.rem = mem_rd_data[LEN_W-1:0];
                r_d.ptr = hdr_next;
                if (mem_rd_data[LEN_W-1:0] == '0) begin
                    r_d.cons = hdr_next;
                    r_d.st   = ST_STAT;
                end else begin
                    r_d.st = ST_WREQ;
                end
            end
            ST_WREQ: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = cfg_buf_base + ADDR_W'(r_q.ptr[OFF_W-1:2]);
                r_d.st      = ST_WAIT;
            end
            ST_WAIT: begin
                r_d.word = mem_rd_data;
                r_d.st   = ST_SEND;
            end
            ST_SEND: begin
                if (tx_ready) begin
                    r_d.rem = r_q.rem - 1'b1;
                    r_d.ptr = byte_next;
                    if (r_q.rem == LEN_W'(1)) begin
                        r_d.cons = end_next;
                        r_d.st   = ST_STAT;
                    end else if (r_q.ptr[1:0] == 2'd3) begin
                        r_d.st = ST_WREQ;
                    end
                end
            end
            ST_STAT: begin
                stat_fire = 1'b1;
                r_d.st    = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cons: '0, ptr: '0, rem: '0, len: '0, word: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_valid = (r_q.st == ST_SEND);
    assign tx_data  = r_q.word[8*r_q.ptr[1:0] +: 8];
    assign tx_last  = (r_q.st == ST_SEND) && (r_q.rem == LEN_W'(1));

    tx_fetch_status #(.STAT_ENTRIES(STAT_ENTRIES), .ADDR_W(ADDR_W)) u_status (
        .clk(clk), .rst_n(rst_n), .fire(stat_fire), .len(r_q.len),
        .stat_base(cfg_stat_base), .wr_en(stat_wr_en), .wr_addr(stat_wr_addr),
        .wr_data(stat_wr_data)
    );

    // R9: an offered byte is held until taken.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
    // R4: the end marker only accompanies a valid byte.
    p_last_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);
    // R2: no read is issued while a byte is being offered.
    p_rd_tx_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && tx_valid));
    // R6: the consumer offset stays word aligned.
    p_cons_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cons[1:0] == 2'b00);
    // R5: the consumer offset stays inside the programmed buffer.
    p_cons_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cons < size_b);
    // R7: a status write happens only once the stream has gone quiet.
    p_stat_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr_en |-> !tx_valid);
endmodule

// File: tb/test_tx_ring_fetch.sv
module test_tx_ring_fetch;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_W      = 2304;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_buf_base = '0;
    logic [11:0] cfg_buf_words = '0;
    logic [15:0] cfg_stat_base = '0;
    logic [10:0] host_prod_idx = '0;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        stat_wr_en;
    logic [15:0] stat_wr_addr;
    logic [31:0] stat_wr_data;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_last;
    logic        tx_ready = 1'b0;

    logic [31:0] mem [0:MEM_W-1];
    logic [15:0] st_addr_q[$];
    logic [31:0] st_data_q[$];
    logic [7:0]  exp_bytes[$];
    int          exp_len[$];
    int          exp_hdr[$];

    int checks = 0;
    int errors = 0;
    int host_off, size_b, base, sbase, pkt_no, salt;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_ring_fetch i_tx_ring_fetch (
        .clk(clk), .rst_n(rst_n), .cfg_buf_base(cfg_buf_base),
        .cfg_buf_words(cfg_buf_words), .cfg_stat_base(cfg_stat_base),
        .host_prod_idx(host_prod_idx), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .stat_wr_en(stat_wr_en), .stat_wr_addr(stat_wr_addr),
        .stat_wr_data(stat_wr_data), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_last(tx_last), .tx_ready(tx_ready)
    );

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= (int'(mem_rd_addr) < MEM_W) ? mem[mem_rd_addr] : 32'h0;
        if (stat_wr_en) begin
            st_addr_q.push_back(stat_wr_addr);
            st_data_q.push_back(stat_wr_data);
        end
    end

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic bit rdy(input int mode, input int c);
        case (mode)
            0: return 1'b1;
            1: return (c % 3) != 2;
            2: return (c % 5) < 2;
            default: return (c % 7) != 0;
        endcase
    endfunction

    task automatic do_reset(input int words, input int b, input int sb);
        @(negedge clk);
        rst_n = 0; host_prod_idx = '0; tx_ready = 0;
        cfg_buf_words = 12'(words); cfg_buf_base = 16'(b); cfg_stat_base = 16'(sb);
        size_b = words * 4; base = b; sbase = sb; host_off = 0; pkt_no = 0;
        st_addr_q.delete(); st_data_q.delete();
        exp_bytes.delete(); exp_len.delete(); exp_hdr.delete();
        repeat (3) @(negedge clk);
        check(!tx_valid && !mem_rd_en && !stat_wr_en, "R1 outputs quiet in reset",
              {tx_valid, mem_rd_en, stat_wr_en}, 0);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic put_packet(input int len, input logic [15:0] junk);
        int a;
        logic [7:0] b;
        exp_hdr.push_back(base + host_off / 4);
        exp_len.push_back(len);
        mem[base + host_off / 4] = {junk, 16'(len)};
        for (int i = 0; i < len; i++) begin
            a = (host_off + 4 + i) % size_b;
            b = 8'(len * 3 + i * 11 + salt);
            mem[base + a / 4][8 * (a % 4) +: 8] = b;
            exp_bytes.push_back(b);
        end
        salt += 7;
        host_off = (((host_off + 4 + len + 3) / 4) * 4) % size_b;
    endtask

    task automatic publish();
        @(negedge clk);
        host_prod_idx = 11'(host_off / 4);
        #1;
    endtask

    task automatic recv_one(input int mode, input string htag);
        int len, hdr, t, got, cyc;
        bit prev_stall, zero_bad;
        logic [7:0] prev_data, e;
        len = exp_len.pop_front();
        hdr = exp_hdr.pop_front();
        t = 0;
        while (!mem_rd_en && t < 2000) begin @(negedge clk); t++; end
        check(mem_rd_en && int'(mem_rd_addr) == hdr, htag, mem_rd_addr, hdr);
        @(negedge clk);
        got = 0; cyc = 0; t = 0; prev_stall = 0; prev_data = '0; zero_bad = 0;
        while (got < len && t < 6000) begin
            tx_ready = rdy(mode, cyc);
            cyc++;
            if (prev_stall) check(tx_valid && tx_data == prev_data, "R9 byte held under stall", tx_data, prev_data);
            if (tx_valid && tx_ready) begin
                e = exp_bytes.pop_front();
                check(tx_data == e, "R3/R5 payload byte", tx_data, e);
                check(tx_last == (got == len - 1), "R4 last marker", tx_last, (got == len - 1));
                got++;
            end
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
            @(negedge clk);
            t++;
        end
        check(got == len, "R2 byte count from header low half", got, len);
        t = 0;
        while (st_addr_q.size() == 0 && t < 2000) begin
            if (tx_valid) zero_bad = 1;
            @(negedge clk);
            t++;
        end
        if (len == 0) check(!zero_bad, "R4 zero length sends nothing", zero_bad, 0);
        check(st_addr_q.size() > 0, "R7 status written", st_addr_q.size(), 1);
        if (st_addr_q.size() > 0) begin
            logic [15:0] sa;
            logic [31:0] sd;
            sa = st_addr_q.pop_front();
            sd = st_data_q.pop_front();
            check(int'(sa) == sbase + pkt_no % 64, "R7 status slot", sa, sbase + pkt_no % 64);
            check(sd == {1'b1, 14'b0, 1'b1, 16'(len)}, "R7 status word", sd, {1'b1, 14'b0, 1'b1, 16'(len)});
        end
        pkt_no++;
    endtask

    task automatic drain(input int mode, input string htag);
        while (exp_len.size() > 0) recv_one(mode, htag);
    endtask

    task automatic idle_check();
        bit bad;
        bad = 0;
        repeat (16) begin
            if (mem_rd_en || tx_valid) bad = 1;
            @(negedge clk);
        end
        check(!bad, "R8 no activity when consumer meets producer", bad, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < MEM_W; i++) mem[i] = 32'h0;
        salt = 1;
        // Small ring: 64 bytes, so headers and payloads wrap often.
        do_reset(16, 32, 1000);
        idle_check();
        for (int len = 0; len <= 40; len++) begin
            put_packet(len, 16'hA5C3 ^ 16'(len));
            publish();
            drain(len % 4, "R6 next header position");
        end
        put_packet(5, 16'h1234);
        put_packet(9, 16'hFFFF);
        put_packet(3, 16'h0F0F);
        publish();
        drain(1, "R6 chained header position");
        for (int k = 0; k < 30; k++) begin
            put_packet(k % 3, 16'h8000);
            publish();
            drain(k % 4, "R6 short packet header");
        end
        idle_check();
        // Full-size ring programmed in words.
        do_reset(2048, 16, 2100);
        for (int k = 0; k < 6; k++) begin
            put_packet(1497 + k, 16'h5A5A);
            publish();
            drain((k % 2) * 3, "R10 header position in full ring");
        end
        idle_check();
        finish_run();
    end
endmodule